// File: doc/BRIEF.md
# Skew-Tolerant Track Word Capture

This block takes sixteen parallel track lines from a multitrack tape reader. A threshold detector has already turned each line into a clean digital level. One line is the index track, which marks that a parallel word is present. The other fifteen carry data bits plus one extra bit. In single-word events that extra bit is a flag. In two-part events it is an identification marker.

Every data line has a retriggerable hold timer. The timer stretches each detected pulse so that tracks arriving early or late relative to the index are still seen. A rising index edge starts a delay. The sample strobe fires at the middle of the hold window, and at that strobe the inverse of every held bit is written into a word register.

In single-word mode each event loads one word. An optional reject setting drops events that carry the flag. In two-part mode an index with the marker loads the first word and opens a timed gate. An index without the marker inside that gate loads the second word. A lockout input from the downstream sequencer silences strobes while earlier data is still being consumed. All timing counts a 1 µs tick enable.

Top module: `track_capture`

## Requirements
- R1: While reset is asserted, and after it is released with no track activity, both word registers read zero and no strobe or drop pulse is asserted.
- R2: A rising edge on the index line (track 15) leads to the sample instant exactly STROBE_TICKS ticks later. The resulting strobe or drop output is high for exactly one clock cycle, starting in the cycle after that sample edge. No strobe or drop output is high in the cycle before it.
- R3: At a strobe, word bit k (k = 0..13, where tracks 0–6 form the low field and tracks 7–13 the high field) is set when track k is not held and cleared when it is held. The stored word is therefore the bitwise inverse of the held data.
- R4: A data pulse is captured when its rising edge falls between 300 ticks before and 299 ticks after the index rising edge, inclusive, with HOLD_TICKS=600 and STROBE_TICKS=300. A pulse whose rising edge is 301 ticks before or 300 ticks after the index edge is not captured.
- R5: A new rising edge on a track that is already held restarts its hold for a full HOLD_TICKS.
- R6: With flag reject enabled in single-word mode, a sample that finds track 14 held raises dropEvent and leaves firstWord unchanged. In two-part mode the reject setting has no effect.
- R7: With flag reject disabled in single-word mode, a sample loads firstWord and pulses firstStrobe whatever the state of track 14.
- R8: In two-part mode, a sample that finds track 14 held loads firstWord, pulses firstStrobe and opens a gate of GATE_TICKS ticks. A later sample without track 14 held, taken while that gate is open, loads secondWord, pulses secondStrobe and closes the gate.
- R9: In two-part mode, a sample without track 14 held, taken while the gate is closed, produces no strobe and leaves both words unchanged.
- R10: When lockout is high in the cycle of the sample edge, no strobe or drop occurs and both words keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | 1 µs timing enable |
| trackIn | input | 16 | Detected track levels; bit 15 index, bit 14 flag/marker, bits 13..0 data |
| twoPartMode | input | 1 | 1 selects two-part events, 0 selects single-word events |
| flagRejectMode | input | 1 | 1 drops single-word events whose flag is held |
| lockout | input | 1 | Suppresses strobe generation while high |
| firstWord | output | 14 | Inverted data from a single-word or first-part sample |
| secondWord | output | 14 | Inverted data from a second-part sample |
| firstStrobe | output | 1 | One-cycle pulse when firstWord is loaded |
| secondStrobe | output | 1 | One-cycle pulse when secondWord is loaded |
| dropEvent | output | 1 | One-cycle pulse when a flagged event is rejected |

## Verification
Two things can happen on the same clock edge: a data track can start its hold on the very edge where the sample is taken, and lockout can rise on that same edge. The bench provokes the first by placing a data rising edge exactly STROBE_TICKS ticks after the index edge. The pulse is judged as missed, because the sample uses the hold state from before that edge, and one tick earlier it is judged as caught. The bench provokes the second by raising lockout only for the sample cycle. That event is judged by the absence of any pulse and by both words keeping their values.

// File: rtl/capture_pkg.sv
package capture_pkg;
  localparam int TRACKS   = 16;
  localparam int INDEX_BIT = TRACKS - 1;
  localparam int FLAG_BIT  = TRACKS - 2;
  localparam int WORD_W    = TRACKS - 2;
  localparam int HELD_W    = TRACKS - 1;

  typedef struct packed {
    logic loadFirst;
    logic loadSecond;
  } capLoad_t;
endpackage

// File: rtl/capture_hold_path.sv
module capture_hold_path
  import capture_pkg::*;
#(
  parameter int HOLD_TICKS = 600
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [HELD_W-1:0] dataIn,
  input  capLoad_t          loads,
  output logic              heldFlag,
  output logic [WORD_W-1:0] firstWord,
  output logic [WORD_W-1:0] secondWord
);
  localparam int HW = $clog2(HOLD_TICKS + 1);

  logic [HELD_W-1:0] prevIn;
  logic [HELD_W-1:0] held;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevIn <= '0;
    else       prevIn <= dataIn;
  end

  for (genvar g = 0; g < HELD_W; g++) begin : gTrack
    logic [HW-1:0] holdCnt;
    logic          riseSeen;
    assign riseSeen = dataIn[g] & ~prevIn[g];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                       holdCnt <= '0;
      else if (riseSeen)               holdCnt <= HW'(HOLD_TICKS);
      else if (tick && holdCnt != '0)  holdCnt <= holdCnt - HW'(1);
    end
    assign held[g] = (holdCnt != '0);

    assert_hold_restart_R5: assert property (@(posedge clk) disable iff (!rstN)
      (dataIn[g] && !prevIn[g]) |=> (holdCnt == HW'(HOLD_TICKS)));
  end

  assign heldFlag = held[FLAG_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      firstWord  <= '0;
      secondWord <= '0;
    end else begin
      if (loads.loadFirst)  firstWord  <= ~held[WORD_W-1:0];
      if (loads.loadSecond) secondWord <= ~held[WORD_W-1:0];
    end
  end

  assert_inverse_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    loads.loadFirst |=> (firstWord == ~$past(held[WORD_W-1:0])));
  assert_first_kept_R10: assert property (@(posedge clk) disable iff (!rstN)
    !loads.loadFirst |=> $stable(firstWord));
  assert_second_kept_R9: assert property (@(posedge clk) disable iff (!rstN)
    !loads.loadSecond |=> $stable(secondWord));
endmodule

// File: rtl/capture_ctrl.sv
module capture_ctrl
  import capture_pkg::*;
#(
  parameter int STROBE_TICKS = 300,
  parameter int GATE_TICKS   = 2000
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     tick,
  input  logic     indexIn,
  input  logic     heldFlag,
  input  logic     twoPartMode,
  input  logic     flagRejectMode,
  input  logic     lockout,
  output capLoad_t loads,
  output logic     firstStrobe,
  output logic     secondStrobe,
  output logic     dropEvent
);
  localparam int DW = $clog2(STROBE_TICKS + 1);
  localparam int GW = $clog2(GATE_TICKS + 1);

  logic          idxPrev;
  logic          idxRise;
  logic [DW-1:0] delayCnt;
  logic [GW-1:0] gateCnt;
  logic          gateOpen;
  logic          fire;
  logic          wantFirst, wantSecond, wantDrop;

  assign idxRise  = indexIn & ~idxPrev;
  assign fire     = tick && (delayCnt == DW'(1)) && !lockout;
  assign gateOpen = (gateCnt != '0);

  always_comb begin
    wantFirst  = 1'b0;
    wantSecond = 1'b0;
    wantDrop   = 1'b0;
    if (fire) begin
      if (twoPartMode) begin
        wantFirst  = heldFlag;
        wantSecond = !heldFlag && gateOpen;
      end else if (flagRejectMode && heldFlag) begin
        wantDrop   = 1'b1;
      end else begin
        wantFirst  = 1'b1;
      end
    end
  end

  assign loads.loadFirst  = wantFirst;
  assign loads.loadSecond = wantSecond;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxPrev  <= 1'b0;
      delayCnt <= '0;
    end else begin
      idxPrev <= indexIn;
      if (idxRise)                      delayCnt <= DW'(STROBE_TICKS);
      else if (tick && delayCnt != '0)  delayCnt <= delayCnt - DW'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          gateCnt <= '0;
    else if (wantFirst && twoPartMode)  gateCnt <= GW'(GATE_TICKS);
    else if (wantSecond)                gateCnt <= '0;
    else if (tick && gateOpen)          gateCnt <= gateCnt - GW'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      firstStrobe  <= 1'b0;
      secondStrobe <= 1'b0;
      dropEvent    <= 1'b0;
    end else begin
      firstStrobe  <= wantFirst;
      secondStrobe <= wantSecond;
      dropEvent    <= wantDrop;
    end
  end

  assert_single_outcome_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({firstStrobe, secondStrobe, dropEvent}));
  assert_lockout_silences_R10: assert property (@(posedge clk) disable iff (!rstN)
    lockout |=> !(firstStrobe || secondStrobe || dropEvent));
  assert_second_in_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
    secondStrobe |-> ($past(gateOpen) && $past(twoPartMode)));
  assert_drop_on_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    dropEvent |-> $past(flagRejectMode && heldFlag && !twoPartMode));
endmodule

// File: rtl/track_capture.sv
module track_capture
  import capture_pkg::*;
#(
  parameter int HOLD_TICKS   = 600,
  parameter int STROBE_TICKS = 300,
  parameter int GATE_TICKS   = 2000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [TRACKS-1:0] trackIn,
  input  logic              twoPartMode,
  input  logic              flagRejectMode,
  input  logic              lockout,
  output logic [WORD_W-1:0] firstWord,
  output logic [WORD_W-1:0] secondWord,
  output logic              firstStrobe,
  output logic              secondStrobe,
  output logic              dropEvent
);
  capLoad_t loads;
  logic     heldFlag;

  capture_ctrl #(
    .STROBE_TICKS(STROBE_TICKS),
    .GATE_TICKS  (GATE_TICKS)
  ) uCtrl (
    .clk           (clk),
    .rstN          (rstN),
    .tick          (tick),
    .indexIn       (trackIn[INDEX_BIT]),
    .heldFlag      (heldFlag),
    .twoPartMode   (twoPartMode),
    .flagRejectMode(flagRejectMode),
    .lockout       (lockout),
    .loads         (loads),
    .firstStrobe   (firstStrobe),
    .secondStrobe  (secondStrobe),
    .dropEvent     (dropEvent)
  );

  capture_hold_path #(
    .HOLD_TICKS(HOLD_TICKS)
  ) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .tick      (tick),
    .dataIn    (trackIn[HELD_W-1:0]),
    .loads     (loads),
    .heldFlag  (heldFlag),
    .firstWord (firstWord),
    .secondWord(secondWord)
  );
endmodule

// File: tb/tb_track_capture.sv
module tb_track_capture;
  logic        clk = 1'b0;
  logic        rstN;
  logic        tick;
  logic [15:0] trackIn;
  logic        twoPartMode, flagRejectMode, lockout;
  logic [13:0] firstWord, secondWord;
  logic        firstStrobe, secondStrobe, dropEvent;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [13:0] modelFirst = '0;
  logic [13:0] modelSecond = '0;

  always #2 clk = ~clk;

  track_capture dut (
    .clk(clk), .rstN(rstN), .tick(tick), .trackIn(trackIn),
    .twoPartMode(twoPartMode), .flagRejectMode(flagRejectMode), .lockout(lockout),
    .firstWord(firstWord), .secondWord(secondWord),
    .firstStrobe(firstStrobe), .secondStrobe(secondStrobe), .dropEvent(dropEvent)
  );

  typedef struct packed {
    logic               twoPart;
    logic               rej;
    logic [1:0]         lock;     // 0 none, 1 whole event, 2 sample cycle only
    logic [14:0]        pat;
    logic signed [15:0] off1;
    logic signed [15:0] off2;
    logic               hasOff2;
    logic [15:0]        idle;
    logic               expF;
    logic               expS;
    logic               expD;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,2'd0,15'h0A35,16'sd0,16'sd0,1'b0,16'd1000,1'b1,1'b0,1'b0},
    '{1'b0,1'b1,2'd0,15'h4123,16'sd0,16'sd0,1'b0,16'd1000,1'b0,1'b0,1'b1},
    '{1'b0,1'b0,2'd0,15'h4321,16'sd0,16'sd0,1'b0,16'd1000,1'b1,1'b0,1'b0},
    '{1'b0,1'b1,2'd0,15'h1F0F,16'sd0,16'sd0,1'b0,16'd1000,1'b1,1'b0,1'b0},
    '{1'b0,1'b0,2'd0,15'h0008,-16'sd300,16'sd0,1'b0,16'd1000,1'b1,1'b0,1'b0},
    '{1'b0,1'b0,2'd0,15'h0008,-16'sd301,16'sd0,1'b0,16'd1000,1'b1,1'b0,1'b0},
    '{1'b0,1'b0,2'd0,15'h0008,16'sd299,16'sd0,1'b0,16'd1000,1'b1,1'b0,1'b0},
    '{1'b0,1'b0,2'd0,15'h0008,16'sd300,16'sd0,1'b0,16'd1000,1'b1,1'b0,1'b0},
    '{1'b0,1'b0,2'd0,15'h0100,-16'sd500,-16'sd250,1'b1,16'd1000,1'b1,1'b0,1'b0},
    '{1'b0,1'b0,2'd0,15'h0100,-16'sd500,16'sd0,1'b0,16'd1000,1'b1,1'b0,1'b0},
    '{1'b0,1'b0,2'd1,15'h0555,16'sd0,16'sd0,1'b0,16'd1000,1'b0,1'b0,1'b0},
    '{1'b1,1'b0,2'd0,15'h4ABC,16'sd0,16'sd0,1'b0,16'd1000,1'b1,1'b0,1'b0},
    '{1'b1,1'b0,2'd0,15'h1357,16'sd0,16'sd0,1'b0,16'd0,1'b0,1'b1,1'b0},
    '{1'b1,1'b0,2'd0,15'h2222,16'sd0,16'sd0,1'b0,16'd3000,1'b0,1'b0,1'b0},
    '{1'b0,1'b0,2'd2,15'h0111,16'sd0,16'sd0,1'b0,16'd1000,1'b0,1'b0,1'b0},
    '{1'b1,1'b1,2'd0,15'h4F00,16'sd0,16'sd0,1'b0,16'd1000,1'b1,1'b0,1'b0},
    '{1'b1,1'b1,2'd0,15'h00FF,16'sd0,16'sd0,1'b0,16'd0,1'b0,1'b1,1'b0}
  };

  function automatic string reqName(input int i);
    case (i)
      0:  return "R3";
      1:  return "R6";
      2:  return "R7";
      3:  return "R6";
      4, 5, 6, 7: return "R4";
      8, 9: return "R5";
      10: return "R10";
      11: return "R8";
      12: return "R8";
      13: return "R9";
      14: return "R10";
      15: return "R6";
      default: return "R8";
    endcase
  endfunction

  function automatic bit inWin(input int o);
    return (o >= -300) && (o <= 299);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic runVec(input int idx);
    vec_t v = VECS[idx];
    int o1 = int'(v.off1);
    int o2 = int'(v.off2);
    bit captured;
    logic [13:0] word;
    repeat (int'(v.idle)) @(posedge clk);
    @(negedge clk);
    twoPartMode    = v.twoPart;
    flagRejectMode = v.rej;
    for (int t = -600; t <= 300; t++) begin
      @(negedge clk);
      if (t == 300)
        check(!(firstStrobe || secondStrobe || dropEvent), "R2", "early pulse",
              {firstStrobe, secondStrobe, dropEvent}, 0);
      trackIn[15]   = (t >= 0) && (t < 50);
      trackIn[14:0] = (((t >= o1) && (t < o1 + 20)) ||
                       (v.hasOff2 && (t >= o2) && (t < o2 + 20))) ? v.pat : 15'h0;
      lockout = (v.lock == 2'd1) || ((v.lock == 2'd2) && (t == 300));
    end
    @(posedge clk);
    @(negedge clk);
    captured = inWin(o1) || (v.hasOff2 && inWin(o2));
    word = captured ? ~v.pat[13:0] : 14'h3FFF;
    if (v.expF) modelFirst  = word;
    if (v.expS) modelSecond = word;
    check(firstStrobe  == v.expF, reqName(idx), "firstStrobe",  firstStrobe,  v.expF);
    check(secondStrobe == v.expS, reqName(idx), "secondStrobe", secondStrobe, v.expS);
    check(dropEvent    == v.expD, reqName(idx), "dropEvent",    dropEvent,    v.expD);
    check(firstWord  == modelFirst,  reqName(idx), "firstWord",  firstWord,  modelFirst);
    check(secondWord == modelSecond, reqName(idx), "secondWord", secondWord, modelSecond);
    trackIn = '0;
    lockout = 1'b0;
    @(negedge clk);
    check(!(firstStrobe || secondStrobe || dropEvent), "R2", "pulse longer than one cycle",
          {firstStrobe, secondStrobe, dropEvent}, 0);
  endtask

  initial begin
    rstN = 1'b0; tick = 1'b1; trackIn = '0;
    twoPartMode = 1'b0; flagRejectMode = 1'b0; lockout = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(firstWord == '0 && secondWord == '0, "R1", "words in reset",
          {firstWord, secondWord}, 0);
    check(!(firstStrobe || secondStrobe || dropEvent), "R1", "pulses in reset",
          {firstStrobe, secondStrobe, dropEvent}, 0);
    rstN = 1'b1;
    repeat (20) @(negedge clk);
    check(firstWord == '0 && secondWord == '0 &&
          !(firstStrobe || secondStrobe || dropEvent), "R1", "idle after reset",
          {firstWord, secondWord}, 0);
    for (int i = 0; i < NV; i++) runVec(i);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule